// File: doc/BRIEF.md
# Queued SPI Master Transfer Controller

This block is an SPI master that works through a queue of transmit entries held in an on-chip transmit FIFO. Each entry carries a 16-bit frame plus two control bits: one marks the last entry of a queue and one zeroes the frame counter. Words shifted in from the slave are stored in a receive FIFO. Software, or a DMA engine driven by the two request lines, uses a small register bus to fill the transmit FIFO and empty the receive FIFO. The same bus reaches control, status and frame-counter registers.

When an entry carrying the last-of-queue bit finishes, the serial engine stops and raises a stop flag. Pushes to the transmit FIFO are still accepted. Software can then flush either FIFO, reload or reset the frame counter, and restart the engine by clearing the flag. A disable bit freezes the block: reads still work, but no other register changes until the bit is cleared again.

Register map (word address on `bus_addr`): 0 control, 1 status, 2 frame counter, 3 transmit push (write only), 4 receive data (read pops). Reads return data on `bus_rdata` one clock after the read cycle.

Top module: `qspi_master`

## Requirements
- R1: Frames are 16 bits, MSB first, SPI mode 0. `spi_cs_n` is low for the whole frame and `spi_sck` is low whenever `spi_cs_n` is high. MOSI changes only on falling SCK, and MISO is sampled on rising SCK. The SCK period is CLK_DIV system clocks.
- R2: A write to address 3 pushes one entry: bits [15:0] are the frame, bit 16 is the end-of-queue bit and bit 17 is the clear-count bit. Entries are sent in push order.
- R3: When a frame whose entry has bit 16 set completes, status bit 0 (stop flag) becomes 1 and no further frame starts. Status bit 1 (running) then reads 0.
- R4: While stopped, pushes are still stored until the transmit FIFO holds DEPTH entries. Pushes beyond that are dropped. Status bits [23:16] give the transmit occupancy.
- R5: Writing status with bit 0 set clears the stop flag, and transfers resume from the next transmit entry.
- R6: Each received frame is stored in the receive FIFO. A read of address 4 returns the oldest word in bits [15:0] and removes it. Status bits [15:8] (receive occupancy) and bit 2 (receive not empty) reflect each pop.
- R7: Writing control with bit 1 set empties the transmit FIFO, and with bit 2 set empties the receive FIFO. Neither bit is stored.
- R8: The 16-bit frame counter at address 2 adds one per completed frame and wraps from 0xFFFF to 0. An entry with bit 17 set leaves the counter at 1 after its frame. A register write loads the counter directly.
- R9: `tx_dma_req` is high while the transmit FIFO is not full. `rx_dma_req` is high while the receive FIFO is not empty.
- R10: Control bit 0 is the disable bit and is always writable. While it is set, reads return current values. Writes to status, counter and push, and the flush bits, have no effect. A read of address 4 returns the oldest word without removing it, and no new frame starts.
- R11: Bus address, write strobe and write data have no effect while `bus_sel` is low.
- R12: After reset: control 0, status 0x00000002, counter 0, `spi_cs_n` high, `spi_sck` low, `tx_dma_req` high, `rx_dma_req` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one clock after a read |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| tx_dma_req | output | 1 | Transmit FIFO has room |
| rx_dma_req | output | 1 | Receive FIFO holds data |

## Verification
The bench targets the stop boundary in several ways. It checks that no frame slips out after the end-of-queue entry, which a design that set the flag one cycle late would allow. It checks that pushes made while stopped are kept until the FIFO is full and then dropped, which an engine that popped early or overwrote a slot would get wrong. It also loads the counter with 0xFFFE so that it must wrap to 0. A clear-count entry must leave the counter at 1; a design that cleared after counting would show 0. In disable mode, the bench tries a pop, a flush, a counter write and a flag clear, and expects each to leave the state intact. A stray write with `bus_sel` low must change nothing.

// File: rtl/qspi_pkg.sv
package qspi_pkg;
  localparam int FRAME_W = 16;
  localparam int ADDR_W  = 3;
  localparam int DATA_W  = 32;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd1;
  localparam logic [ADDR_W-1:0] A_COUNT  = 3'd2;
  localparam logic [ADDR_W-1:0] A_PUSH   = 3'd3;
  localparam logic [ADDR_W-1:0] A_RXDATA = 3'd4;

  typedef struct packed {
    logic               clr_cnt;
    logic               last;
    logic [FRAME_W-1:0] data;
  } tx_entry_t;
endpackage

// File: rtl/qspi_fifo.sv
module qspi_fifo #(
  parameter int W     = 18,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         flush,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R4: occupancy never exceeds the depth
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  // R7: a flush leaves the FIFO empty on the next cycle
  a_r7_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush |=> (count == '0));
endmodule

// File: rtl/qspi_shifter.sv
module qspi_shifter #(
  parameter int W       = 16,
  parameter int CLK_DIV = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] load_data,
  output logic         take,
  output logic         done,
  output logic [W-1:0] rx_word,
  output logic         sck,
  output logic         cs_n,
  output logic         mosi,
  input  logic         miso
);
  localparam int HALF = CLK_DIV / 2;
  localparam int DW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int BW   = $clog2(W);

  logic          busy;
  logic [DW-1:0] div_cnt;
  logic [BW-1:0] bit_cnt;
  logic [W-1:0]  tx_sh, rx_sh;

  assign take = go && !busy;
  assign mosi = tx_sh[W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      cs_n    <= 1'b1;
      sck     <= 1'b0;
      done    <= 1'b0;
      div_cnt <= '0;
      bit_cnt <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      rx_word <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (go) begin
          busy    <= 1'b1;
          cs_n    <= 1'b0;
          sck     <= 1'b0;
          tx_sh   <= load_data;
          div_cnt <= '0;
          bit_cnt <= '0;
        end
      end else if (div_cnt == DW'(HALF-1)) begin
        div_cnt <= '0;
        if (!sck) begin
          sck   <= 1'b1;
          rx_sh <= {rx_sh[W-2:0], miso};
        end else begin
          sck <= 1'b0;
          if (bit_cnt == BW'(W-1)) begin
            busy    <= 1'b0;
            cs_n    <= 1'b1;
            done    <= 1'b1;
            rx_word <= rx_sh;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
            tx_sh   <= tx_sh << 1;
          end
        end
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end

  // R1: clock idles low outside a frame
  a_r1_sck_idle_low: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sck);
  // R1: data out holds across a rising clock edge
  a_r1_mosi_hold: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && $rose(sck)) |-> $stable(mosi));
  // R1: a frame ends with chip select released
  a_r1_done_releases_cs: assert property (@(posedge clk) disable iff (rst)
    done |-> cs_n);
endmodule

// File: rtl/qspi_master.sv
module qspi_master
  import qspi_pkg::*;
#(
  parameter int DEPTH   = 4,
  parameter int CLK_DIV = 4,
  parameter int CNT_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              tx_dma_req,
  output logic              rx_dma_req
);
  localparam int EW = $bits(tx_entry_t);
  localparam int CW = $clog2(DEPTH+1);

  // gated bus: nothing toggles inside unless selected
  logic [ADDR_W-1:0] a_g;
  logic [DATA_W-1:0] wd_g;
  logic              wr_g, rd_g;
  assign a_g  = bus_sel ? bus_addr : '0;
  assign wd_g = bus_sel ? bus_wdata : '0;
  assign wr_g = bus_sel && bus_wr;
  assign rd_g = bus_sel && !bus_wr;

  logic             dis_q, stop_q, cur_last, cur_clr;
  logic [CNT_W-1:0] fcnt;

  logic wr_ctrl, wr_stat, wr_cnt, wr_push, rd_pop;
  assign wr_ctrl = wr_g && (a_g == A_CTRL);
  assign wr_stat = wr_g && (a_g == A_STATUS) && !dis_q;
  assign wr_cnt  = wr_g && (a_g == A_COUNT)  && !dis_q;
  assign wr_push = wr_g && (a_g == A_PUSH)   && !dis_q;
  assign rd_pop  = rd_g && (a_g == A_RXDATA) && !dis_q;

  logic tx_flush, rx_flush;
  assign tx_flush = wr_ctrl && !dis_q && wd_g[1];
  assign rx_flush = wr_ctrl && !dis_q && wd_g[2];

  tx_entry_t        tx_head;
  logic [EW-1:0]    tx_dout;
  logic [CW-1:0]    tx_cnt, rx_cnt;
  logic             tx_full, tx_empty, rx_full, rx_empty;
  logic [FRAME_W-1:0] rx_dout, rx_word;
  logic             go, take, sh_done;

  assign tx_head = tx_entry_t'(tx_dout);

  qspi_fifo #(.W(EW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .flush(tx_flush),
    .push(wr_push), .din(wd_g[EW-1:0]),
    .pop(take), .dout(tx_dout),
    .count(tx_cnt), .full(tx_full), .empty(tx_empty)
  );

  qspi_fifo #(.W(FRAME_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .flush(rx_flush),
    .push(sh_done), .din(rx_word),
    .pop(rd_pop), .dout(rx_dout),
    .count(rx_cnt), .full(rx_full), .empty(rx_empty)
  );

  assign go = !dis_q && !stop_q && !tx_empty && !sh_done;

  qspi_shifter #(.W(FRAME_W), .CLK_DIV(CLK_DIV)) u_shift (
    .clk(clk), .rst(rst), .go(go), .load_data(tx_head.data),
    .take(take), .done(sh_done), .rx_word(rx_word),
    .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi), .miso(spi_miso)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dis_q    <= 1'b0;
      stop_q   <= 1'b0;
      fcnt     <= '0;
      cur_last <= 1'b0;
      cur_clr  <= 1'b0;
    end else begin
      if (wr_ctrl) dis_q <= wd_g[0];
      if (take) begin
        cur_last <= tx_head.last;
        cur_clr  <= tx_head.clr_cnt;
      end
      if (sh_done && cur_last)     stop_q <= 1'b1;
      else if (wr_stat && wd_g[0]) stop_q <= 1'b0;
      if (sh_done)     fcnt <= cur_clr ? CNT_W'(1) : fcnt + 1'b1;
      else if (wr_cnt) fcnt <= wd_g[CNT_W-1:0];
    end
  end

  logic running;
  assign running = !dis_q && !stop_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (rd_g) begin
      case (a_g)
        A_CTRL:   bus_rdata <= {31'd0, dis_q};
        A_STATUS: bus_rdata <= {8'd0, 8'(tx_cnt), 8'(rx_cnt), 5'd0,
                                !rx_empty, running, stop_q};
        A_COUNT:  bus_rdata <= DATA_W'(fcnt);
        A_RXDATA: bus_rdata <= DATA_W'(rx_dout);
        default:  bus_rdata <= '0;
      endcase
    end
  end

  assign tx_dma_req = !tx_full;
  assign rx_dma_req = !rx_empty;

  logic unused_bits;
  assign unused_bits = ^{wd_g, rx_full};

  // R3: a frame never begins while the stop flag is set
  a_r3_no_start_when_stopped: assert property (@(posedge clk) disable iff (rst)
    $fell(spi_cs_n) |-> !$past(stop_q));
  // R3: a last-of-queue frame raises the stop flag
  a_r3_stop_raised: assert property (@(posedge clk) disable iff (rst)
    (sh_done && cur_last) |=> stop_q);
  // R8: each completed frame steps or restarts the counter
  a_r8_count_step: assert property (@(posedge clk) disable iff (rst)
    sh_done |=> (fcnt == ($past(cur_clr) ? CNT_W'(1) : $past(fcnt) + 1'b1)));
  // R10: while disabled and idle, the counter is frozen
  a_r10_disabled_count_hold: assert property (@(posedge clk) disable iff (rst)
    (dis_q && !sh_done) |=> $stable(fcnt));
endmodule

// File: tb/qspi_master_bench.sv
module qspi_master_bench;
  localparam int DEPTH   = 4;
  localparam int CLK_DIV = 4;

  logic        clk = 1'b0;
  logic        rst;
  logic        bus_sel, bus_wr;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        spi_sck, spi_cs_n, spi_mosi, spi_miso;
  logic        tx_dma_req, rx_dma_req;

  always #5 clk = ~clk;

  qspi_master #(.DEPTH(DEPTH), .CLK_DIV(CLK_DIV), .CNT_W(16)) u_qspi_master (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req)
  );

  int n_run = 0, n_fail = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // behavioural slave and line monitor
  function automatic logic [15:0] reply(input int n);
    return 16'h5A0F + 16'(n) * 16'h0301;
  endfunction

  logic [15:0] s_out, s_in;
  int          frame_idx = 0;
  logic [15:0] got_q[$];
  logic [15:0] rx_exp[$];
  int          proto_err = 0, per_err = 0;
  time         last_rise = 0;
  bit          in_frame = 0;

  always @(negedge spi_cs_n) begin
    s_out    = reply(frame_idx);
    spi_miso = s_out[15];
    in_frame = 1;
    last_rise = 0;
  end
  always @(posedge spi_sck) begin
    if (!spi_cs_n) begin
      s_in = {s_in[14:0], spi_mosi};
      if (last_rise != 0 && ($time - last_rise) != CLK_DIV * 10) per_err++;
      last_rise = $time;
    end
  end
  always @(negedge spi_sck) begin
    if (!spi_cs_n) begin
      s_out    = s_out << 1;
      spi_miso = s_out[15];
    end
  end
  always @(posedge spi_cs_n) begin
    if (!rst && in_frame) begin
      got_q.push_back(s_in);
      if (rx_exp.size() < DEPTH) rx_exp.push_back(reply(frame_idx));
      frame_idx++;
      in_frame = 0;
    end
  end
  always @(negedge clk) begin
    if (!rst && spi_cs_n === 1'b1 && spi_sck !== 1'b0) proto_err++;
  end

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  task automatic wait_stop();
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      bus_read(3'd1, v);
      if (v[0]) break;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    rst = 1; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0; spi_miso = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R12 reset state
    check("R12 cs_n", {31'd0, spi_cs_n}, 32'd1);
    check("R12 sck", {31'd0, spi_sck}, 32'd0);
    check("R12 tx_req", {31'd0, tx_dma_req}, 32'd1);
    check("R12 rx_req", {31'd0, rx_dma_req}, 32'd0);
    bus_read(3'd1, v); check("R12 status", v, 32'h0000_0002);
    bus_read(3'd2, v); check("R12 count", v, 32'd0);
    bus_read(3'd0, v); check("R12 ctrl", v, 32'd0);

    // R2/R1/R3: two-entry queue, second marked last
    bus_write(3'd3, 32'h0000_A5C3);
    bus_write(3'd3, 32'h0001_1234);
    wait_stop();
    check("R2 frame count", got_q.size(), 2);
    check("R2 frame0", got_q[0], 16'hA5C3);
    check("R2 frame1", got_q[1], 16'h1234);
    bus_read(3'd1, v); check("R3 stopped status", v, 32'h0000_0205);
    bus_read(3'd2, v); check("R8 count after 2", v, 32'd2);
    check("R9 rx_req set", {31'd0, rx_dma_req}, 32'd1);

    // R4: stopped engine keeps accepting pushes until full
    bus_write(3'd3, 32'h0000_0F0F);
    bus_write(3'd3, 32'h0001_00FF);
    bus_write(3'd3, 32'h0000_8001);
    bus_write(3'd3, 32'h0000_7FFE);
    bus_write(3'd3, 32'h0000_3333);
    repeat (200) @(negedge clk);
    check("R3 no frame while stopped", got_q.size(), 2);
    bus_read(3'd1, v); check("R4 tx full count", v, 32'h0004_0205);
    check("R9 tx_req when full", {31'd0, tx_dma_req}, 32'd0);

    // R6: pops
    bus_read(3'd4, v); check("R6 pop0", v, {16'd0, rx_exp.pop_front()});
    bus_read(3'd1, v); check("R6 status after pop", v, 32'h0004_0105);
    bus_read(3'd4, v); check("R6 pop1", v, {16'd0, rx_exp.pop_front()});
    bus_read(3'd1, v); check("R6 status empty", v, 32'h0004_0001);
    check("R9 rx_req clear", {31'd0, rx_dma_req}, 32'd0);

    // R7: transmit flush
    bus_write(3'd0, 32'h0000_0002);
    bus_read(3'd1, v); check("R7 tx flushed", v, 32'h0000_0001);
    check("R9 tx_req after flush", {31'd0, tx_dma_req}, 32'd1);
    bus_read(3'd0, v); check("R7 flush bit not stored", v, 32'd0);

    // R8 direct load and wrap, R5 restart
    bus_write(3'd2, 32'h0000_FFFE);
    bus_read(3'd2, v); check("R8 direct load", v, 32'h0000_FFFE);
    bus_write(3'd3, 32'h0000_0F0F);
    bus_write(3'd3, 32'h0001_00FF);
    bus_write(3'd1, 32'h0000_0001);
    wait_stop();
    check("R5 resumed frames", got_q.size(), 4);
    check("R5 frame2", got_q[2], 16'h0F0F);
    check("R5 frame3", got_q[3], 16'h00FF);
    bus_read(3'd2, v); check("R8 wrap", v, 32'd0);

    // R8 clear-count entry
    bus_write(3'd3, 32'h0003_BEEF);
    bus_write(3'd1, 32'h0000_0001);
    wait_stop();
    check("R8 clr frame", got_q[4], 16'hBEEF);
    bus_read(3'd2, v); check("R8 clr leaves 1", v, 32'd1);
    bus_read(3'd1, v); check("R6 rx three", v, 32'h0000_0305);

    // R10: disable mode
    bus_write(3'd0, 32'h0000_0001);
    bus_read(3'd0, v); check("R10 ctrl disabled", v, 32'd1);
    bus_write(3'd3, 32'h0000_4444);
    bus_write(3'd2, 32'h0000_1234);
    bus_write(3'd1, 32'h0000_0001);
    bus_read(3'd2, v); check("R10 count write ignored", v, 32'd1);
    bus_read(3'd4, v); check("R10 read no pop data", v, {16'd0, rx_exp[0]});
    bus_write(3'd0, 32'h0000_0005);
    bus_read(3'd1, v); check("R10 status frozen", v, 32'h0000_0305);
    check("R10 rx_req held", {31'd0, rx_dma_req}, 32'd1);
    bus_write(3'd0, 32'h0000_0000);
    bus_read(3'd0, v); check("R10 ctrl re-enabled", v, 32'd0);

    // R7: receive flush
    bus_write(3'd0, 32'h0000_0004);
    rx_exp.delete();
    bus_read(3'd1, v); check("R7 rx flushed", v, 32'h0000_0001);

    // R11: unselected bus cycle does nothing
    @(negedge clk);
    bus_sel = 0; bus_wr = 1; bus_addr = 3'd2; bus_wdata = 32'h0000_BEEF;
    @(negedge clk);
    bus_addr = 3'd3; bus_wdata = 32'h0000_5555;
    @(negedge clk);
    bus_wr = 0;
    bus_read(3'd2, v); check("R11 count untouched", v, 32'd1);
    bus_read(3'd1, v); check("R11 no push", v, 32'h0000_0001);

    // R1: line protocol over the whole run
    check("R1 sck idle low", proto_err, 0);
    check("R1 sck period", per_err, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule